// File: doc/BRIEF.md
# Prescaled Auto-Reload Interval Timer

This block is an up-counting interval timer attached to a simple 32-bit register bus. Software picks a clock division ratio and a limit value, then starts the counter. Each time the counter reaches the limit, the counter wraps to zero and a sticky update flag is set. The interrupt line is asserted while that flag is set and the interrupt enable bit is on. Software uses the block in two ways. It can run it periodically, with the counter wrapping forever. It can also run it single-shot, where the timer stops itself after one update.

The limit can be buffered. With buffering on, a new limit waits in a holding register until the next update event. With buffering off, it takes effect at once. The division ratio is always buffered: a written value only reaches the active divider on an update event. Software can force that event through the event register, and a forced update behaves like a natural wrap. The counter width is a parameter of 16 or 32 bits. The limit register keeps only that many bits, so software can find the width by writing all ones and reading the value back.

Register offsets on the 6-bit byte address are: control 0x00, interrupt enable 0x04, status 0x08, event 0x0C, prescaler 0x10 and limit 0x14. Control bit 0 is run, bit 1 is single-shot and bit 2 is limit buffering. Reads are combinational. Writes take effect at the clock edge on which the write enable is high.

Top module: `ivl_timer`

## Requirements
- R1: After reset, every register reads 0 and the interrupt output is low.
- R2: With prescaler value P (division ratio minus one) and active limit L, running updates occur exactly (L+1)*(P+1) clocks apart.
- R3: The counter counts up from 0. On the tick where it equals the active limit it returns to 0 and sets the update flag (status bit 0).
- R4: With buffering on (control bit 2 = 1), a limit write is held back. The active limit changes only at the next update event, so the current period keeps the old limit.
- R5: With buffering off, a limit write changes the active limit in the clock after the write.
- R6: With single-shot on (control bit 1 = 1), the timer produces one update and then clears control bit 0 by itself. No further update follows.
- R7: The update flag stays set until software writes 0 to status bit 0. Writing 1 to that bit leaves it unchanged.
- R8: The interrupt output is high exactly when the update flag and interrupt enable bit 0 are both 1.
- R9: Writing 1 to event bit 0 forces an update, whether the timer is running or stopped. It sets the flag, clears the counter and the prescale count, and loads the buffered prescaler and limit into the active copies.
- R10: A prescaler write takes effect only at the next update event. The current period keeps the old division ratio.
- R11: The limit register keeps only the counter width: writing 0xFFFFFFFF reads back 0x0000FFFF at 16 bits and 0xFFFFFFFF at 32 bits. The prescaler register keeps only its own width in the same way.
- R12: Writing 0 to control stops counting from the next clock. No update occurs while stopped, and the count is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Register byte address |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the addressed register |
| irqOut | output | 1 | Update interrupt request |

## Verification
The prescale count, the counter and the active limit are not visible at the ports, so faults in them show up in update timing. A wrong active division ratio or limit shifts the gap between interrupt edges within one period. A wrong buffering decision only shows at the following update, so those checks measure two consecutive gaps. A lost single-shot stop or a counter that keeps running after a stop shows as an extra interrupt within one limit period. The bench compares read data and the interrupt line against a behavioural model on every clock, so any of these faults is reported in the cycle where it first reaches a port.

// File: rtl/ivl_timer_pkg.sv
`timescale 1ns/1ps
package ivl_timer_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_EVT  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_PSC  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_ARR  = 6'h14;

  localparam int BIT_RUN  = 0;
  localparam int BIT_ONCE = 1;
  localparam int BIT_BUF  = 2;

  // control -> datapath strobes
  typedef struct packed {
    logic run;        // counting allowed this cycle
    logic forceUpd;   // software-forced update event
    logic arrLoadNow; // unbuffered limit write, load active limit directly
  } tmrStrobe_t;
endpackage

// File: rtl/ivl_timer_dp.sv
`timescale 1ns/1ps
module ivl_timer_dp
  import ivl_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic [PSC_W-1:0] pscVal,
  input  logic [CNT_W-1:0] arrShadow,
  input  logic [CNT_W-1:0] arrWrData,
  output logic             updNat
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [PSC_W-1:0] PSC_ONE = {{(PSC_W-1){1'b0}}, 1'b1};

  logic [PSC_W-1:0] pscCnt;
  logic [PSC_W-1:0] pscAct;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] arrAct;
  logic             tick;

  assign tick   = strb.run && (pscCnt == pscAct);
  assign updNat = tick && (cnt == arrAct);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscCnt <= '0;
      pscAct <= '0;
      cnt    <= '0;
      arrAct <= '0;
    end else begin
      if (strb.forceUpd || updNat) begin
        cnt    <= '0;
        pscCnt <= '0;
        pscAct <= pscVal;
        arrAct <= arrShadow;
      end else if (strb.run) begin
        if (tick) begin
          pscCnt <= '0;
          cnt    <= cnt + CNT_ONE;
        end else begin
          pscCnt <= pscCnt + PSC_ONE;
        end
      end
      // an unbuffered write overrides the update reload
      if (strb.arrLoadNow) arrAct <= arrWrData;
    end
  end

  // forced update restarts both counters and latches the divider (R9)
  p_force_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceUpd |=> (cnt == '0) && (pscCnt == '0) && (pscAct == $past(pscVal)));

  // stopped counter holds its value (R12)
  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.forceUpd) |=> $stable(cnt));

  // active limit only moves on update or direct write (R4)
  p_limit_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.forceUpd && !updNat && !strb.arrLoadNow) |=> $stable(arrAct));

  // active divider only moves on update (R10)
  p_psc_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.forceUpd && !updNat) |=> $stable(pscAct));
endmodule

// File: rtl/ivl_timer_ctrl.sv
`timescale 1ns/1ps
module ivl_timer_ctrl
  import ivl_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              updNat,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut,
  output tmrStrobe_t        strb,
  output logic [PSC_W-1:0]  pscVal,
  output logic [CNT_W-1:0]  arrShadow,
  output logic [CNT_W-1:0]  arrWrData
);
  logic runBit, onceBit, bufBit, ienBit, flagBit;
  logic [PSC_W-1:0]  pscReg;
  logic [CNT_W-1:0]  arrReg;
  logic [DATA_W-1:0] arrRd, pscRd;
  logic wrCtrl, wrIen, wrStat, wrEvt, wrPsc, wrArr;
  logic updAny;

  assign wrCtrl = busWrEn && (busAddr == OFS_CTRL);
  assign wrIen  = busWrEn && (busAddr == OFS_IEN);
  assign wrStat = busWrEn && (busAddr == OFS_STAT);
  assign wrEvt  = busWrEn && (busAddr == OFS_EVT);
  assign wrPsc  = busWrEn && (busAddr == OFS_PSC);
  assign wrArr  = busWrEn && (busAddr == OFS_ARR);

  assign strb.run        = runBit;
  assign strb.forceUpd   = wrEvt && busWrData[0];
  assign strb.arrLoadNow = wrArr && !bufBit;
  assign updAny          = updNat || strb.forceUpd;

  assign pscVal    = pscReg;
  assign arrShadow = arrReg;
  assign arrWrData = busWrData[CNT_W-1:0];
  assign irqOut    = flagBit && ienBit;

  // width selection of the readback paths
  if (CNT_W < DATA_W) begin : g_arrNarrow
    logic unusedArrHi;
    assign unusedArrHi = ^busWrData[DATA_W-1:CNT_W];
    assign arrRd = {{(DATA_W-CNT_W){1'b0}}, arrReg};
  end else begin : g_arrFull
    assign arrRd = arrReg;
  end

  if (PSC_W < DATA_W) begin : g_pscNarrow
    logic unusedPscHi;
    assign unusedPscHi = ^busWrData[DATA_W-1:PSC_W];
    assign pscRd = {{(DATA_W-PSC_W){1'b0}}, pscReg};
  end else begin : g_pscFull
    assign pscRd = pscReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit  <= 1'b0;
      onceBit <= 1'b0;
      bufBit  <= 1'b0;
      ienBit  <= 1'b0;
      flagBit <= 1'b0;
      pscReg  <= '0;
      arrReg  <= '0;
    end else begin
      if (updNat && onceBit) runBit <= 1'b0;
      if (wrCtrl) begin
        runBit  <= busWrData[BIT_RUN];
        onceBit <= busWrData[BIT_ONCE];
        bufBit  <= busWrData[BIT_BUF];
      end
      if (wrIen) ienBit <= busWrData[0];
      if (wrStat) flagBit <= flagBit && busWrData[0];
      if (updAny) flagBit <= 1'b1;
      if (wrPsc) pscReg <= busWrData[PSC_W-1:0];
      if (wrArr) arrReg <= busWrData[CNT_W-1:0];
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      OFS_CTRL: begin
        busRdData[BIT_RUN]  = runBit;
        busRdData[BIT_ONCE] = onceBit;
        busRdData[BIT_BUF]  = bufBit;
      end
      OFS_IEN:  busRdData[0] = ienBit;
      OFS_STAT: busRdData[0] = flagBit;
      OFS_PSC:  busRdData = pscRd;
      OFS_ARR:  busRdData = arrRd;
      default:  busRdData = '0;
    endcase
  end

  // flag only rises from an update event (R3)
  p_flag_src_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagBit) |-> $past(updAny));

  // single-shot clears run after its update (R6)
  p_once_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (updNat && onceBit && !wrCtrl) |=> !runBit);

  // writing 0 clears the flag when no update competes (R7)
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && !busWrData[0] && !updAny) |=> !flagBit);

  // flag is sticky against writes of 1 (R7)
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (flagBit && !(wrStat && !busWrData[0])) |=> flagBit);
endmodule

// File: rtl/ivl_timer.sv
`timescale 1ns/1ps
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        irqOut
);
  tmrStrobe_t       strb;
  logic [PSC_W-1:0] pscVal;
  logic [CNT_W-1:0] arrShadow;
  logic [CNT_W-1:0] arrWrData;
  logic             updNat;

  ivl_timer_ctrl #(.CNT_W(CNT_W), .PSC_W(PSC_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .updNat    (updNat),
    .busRdData (busRdData),
    .irqOut    (irqOut),
    .strb      (strb),
    .pscVal    (pscVal),
    .arrShadow (arrShadow),
    .arrWrData (arrWrData)
  );

  ivl_timer_dp #(.CNT_W(CNT_W), .PSC_W(PSC_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pscVal    (pscVal),
    .arrShadow (arrShadow),
    .arrWrData (arrWrData),
    .updNat    (updNat)
  );
endmodule

// File: tb/ivl_timer_tb_top.sv
`timescale 1ns/1ps
module ivl_timer_tb_top;
  localparam int CNT_W = 16;
  localparam int PSC_W = 16;
  localparam logic [31:0] CMASK = (CNT_W >= 32) ? 32'hFFFF_FFFF : ((32'h1 << CNT_W) - 32'h1);
  localparam logic [31:0] PMASK = (PSC_W >= 32) ? 32'hFFFF_FFFF : ((32'h1 << PSC_W) - 32'h1);
  localparam logic [5:0] A_CTRL = 6'h00, A_IEN = 6'h04, A_STAT = 6'h08,
                         A_EVT = 6'h0C, A_PSC = 6'h10, A_ARR = 6'h14;

  logic        clk = 1'b0;
  logic        rstN;
  logic [5:0]  busAddr;
  logic        busWrEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic        irqOut;

  int nRun = 0;
  int nFail = 0;
  int cyc = 0;
  bit doneFlag = 1'b0;

  always #2 clk = ~clk;

  ivl_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  // behavioural reference
  bit mEn, mOnce, mBuf, mIen, mFlag;
  logic [31:0] mPsc, mArr, mPscAct, mArrAct, mPscCnt, mCnt;
  bit frc, tk, upd;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mEn = 0; mOnce = 0; mBuf = 0; mIen = 0; mFlag = 0;
      mPsc = 0; mArr = 0; mPscAct = 0; mArrAct = 0; mPscCnt = 0; mCnt = 0;
    end else begin
      cyc++;
      frc = busWrEn && busAddr == A_EVT && busWrData[0];
      tk  = mEn && (mPscCnt == mPscAct);
      upd = tk && (mCnt == mArrAct);
      if (frc || upd) begin
        mCnt = 0; mPscCnt = 0; mPscAct = mPsc; mArrAct = mArr; mFlag = 1;
        if (upd && mOnce) mEn = 0;
      end else if (mEn) begin
        if (tk) begin mPscCnt = 0; mCnt = (mCnt + 1) & CMASK; end
        else mPscCnt = (mPscCnt + 1) & PMASK;
      end
      if (busWrEn) begin
        case (busAddr)
          A_CTRL: begin mEn = busWrData[0]; mOnce = busWrData[1]; mBuf = busWrData[2]; end
          A_IEN:  mIen = busWrData[0];
          A_STAT: if (!(frc || upd) && !busWrData[0]) mFlag = 0;
          A_PSC:  mPsc = busWrData & PMASK;
          A_ARR:  begin mArr = busWrData & CMASK; if (!mBuf) mArrAct = busWrData & CMASK; end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] modelRead(input logic [5:0] a);
    case (a)
      A_CTRL: return {29'd0, mBuf, mOnce, mEn};
      A_IEN:  return {31'd0, mIen};
      A_STAT: return {31'd0, mFlag};
      A_PSC:  return mPsc;
      A_ARR:  return mArr;
      default: return 32'd0;
    endcase
  endfunction

  // per-cycle comparison, away from both edges
  always @(negedge clk) begin
    #1;
    if (rstN && !doneFlag) begin
      nRun++;
      if (busRdData !== modelRead(busAddr)) begin
        nFail++;
        $display("FAIL R3 read addr %h act %h exp %h cyc %0d", busAddr, busRdData, modelRead(busAddr), cyc);
      end
      nRun++;
      if (irqOut !== (mFlag && mIen)) begin
        nFail++;
        $display("FAIL R8 irq act %0b exp %0b cyc %0d", irqOut, mFlag && mIen, cyc);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); #0.5;
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    @(negedge clk); #0.5;
    busWrEn = 1'b0; busAddr = A_STAT; busWrData = 32'd0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); #0.5;
    busAddr = a;
    #0.3;
    d = busRdData;
    @(negedge clk); #0.5;
    busAddr = A_STAT;
  endtask

  // waits for an interrupt, stamps it, clears the flag
  task automatic nextUpd(output int st);
    bit seen = 0;
    st = -1;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk); #0.8;
      if (irqOut) begin seen = 1; st = cyc; end
    end
    if (!seen) begin nFail++; nRun++; $display("FAIL R3 no update seen act 0 exp 1"); end
    busWrite(A_STAT, 32'd0);
  endtask

  task automatic finishRun();
    doneFlag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog act timeout exp done");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    int a, b, c, d, e, f, g, cEn;
    rstN = 1'b0; busWrEn = 1'b0; busAddr = A_STAT; busWrData = 32'd0;
    repeat (3) @(negedge clk);
    #0.5 rstN = 1'b1;

    // R1 reset state
    busRead(A_CTRL, rd); check("R1 ctrl", rd, 0);
    busRead(A_STAT, rd); check("R1 stat", rd, 0);
    busRead(A_ARR, rd);  check("R1 limit", rd, 0);
    busRead(A_PSC, rd);  check("R1 psc", rd, 0);
    check("R1 irq", {31'd0, irqOut}, 0);

    // R11 width probe
    busWrite(A_ARR, 32'hFFFF_FFFF);
    busRead(A_ARR, rd); check("R11 limit width", rd, CMASK);
    busWrite(A_PSC, 32'hFFFF_FFFF);
    busRead(A_PSC, rd); check("R11 psc width", rd, PMASK);
    busWrite(A_ARR, 0);

    // R9 forced update latches psc, R7 sticky flag
    busWrite(A_PSC, 2);
    busWrite(A_EVT, 1);
    busRead(A_STAT, rd); check("R9 forced flag", rd, 1);
    busWrite(A_STAT, 1);
    busRead(A_STAT, rd); check("R7 write 1 keeps flag", rd, 1);
    busWrite(A_STAT, 0);
    busRead(A_STAT, rd); check("R7 write 0 clears", rd, 0);

    // R2/R3 periodic spacing, limit 4, psc 2
    busWrite(A_ARR, 4);
    busWrite(A_IEN, 1);
    busWrite(A_CTRL, 1);
    nextUpd(a); nextUpd(b);
    check("R2 period", b - a, 15);

    // R4 buffered limit
    busWrite(A_CTRL, 5);
    nextUpd(a);
    busWrite(A_ARR, 9);
    nextUpd(b); check("R4 old limit kept", b - a, 15);
    nextUpd(c); check("R4 new limit at update", c - b, 30);

    // R10 buffered prescaler
    busWrite(A_PSC, 0);
    nextUpd(d); check("R10 old psc kept", d - c, 30);
    nextUpd(e); check("R10 new psc at update", e - d, 10);

    // R5 unbuffered limit
    busWrite(A_CTRL, 1);
    nextUpd(f);
    busWrite(A_ARR, 5);
    nextUpd(g); check("R5 immediate limit", g - f, 6);

    // R12 stop
    busWrite(A_CTRL, 0);
    repeat (80) @(negedge clk);
    busRead(A_STAT, rd); check("R12 no update while stopped", rd, 0);

    // R8 gating
    busWrite(A_EVT, 1);
    busWrite(A_IEN, 0);
    #0.3 check("R8 irq masked", {31'd0, irqOut}, 0);
    busRead(A_STAT, rd); check("R8 flag still set", rd, 1);
    busWrite(A_IEN, 1);
    #0.3 check("R8 irq unmasked", {31'd0, irqOut}, 1);
    busWrite(A_STAT, 0);

    // R9 forced update loads psc 4 while stopped
    busWrite(A_PSC, 4);
    busWrite(A_EVT, 1);
    busWrite(A_STAT, 0);
    busWrite(A_ARR, 1);
    @(negedge clk); #0.5;
    busAddr = A_CTRL; busWrEn = 1'b1; busWrData = 1;
    @(negedge clk); cEn = cyc; #0.5;
    busWrEn = 1'b0; busAddr = A_STAT; busWrData = 0;
    nextUpd(a); check("R9 latched psc timing", a - cEn, 10);

    // R6 single-shot
    busWrite(A_CTRL, 0);
    busWrite(A_ARR, 3);
    busWrite(A_PSC, 0);
    busWrite(A_EVT, 1);
    busWrite(A_STAT, 0);
    @(negedge clk); #0.5;
    busAddr = A_CTRL; busWrEn = 1'b1; busWrData = 3;
    @(negedge clk); cEn = cyc; #0.5;
    busWrEn = 1'b0; busAddr = A_STAT; busWrData = 0;
    nextUpd(a); check("R6 single update timing", a - cEn, 4);
    busRead(A_CTRL, rd); check("R6 run self-cleared", rd, 2);
    repeat (40) @(negedge clk);
    busRead(A_STAT, rd); check("R6 no second update", rd, 0);
    #0.3 check("R6 irq low", {31'd0, irqOut}, 0);

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule